// File: doc/BRIEF.md
# ADC Conversion Control Unit

This block is the digital front end of a successive-approximation analog-to-digital converter inside a microcontroller. Software uses a small register interface for three tasks: it picks an input channel, it starts a conversion, and it collects the result. A sequencer sends a single start pulse to a behavioural converter core. It then waits for the core's done strobe and stores the result word in two byte-wide result registers. In that same clock edge it clears the start bit. The start bit also serves as the busy flag.

The completion is detected on the falling transition of the start bit. That transition sets a sticky end-of-conversion request flag. The interrupt line to the CPU is asserted only when this flag is set and software has enabled the interrupt. A warm reset and the two standby power states both clear the control state, but they leave the result registers untouched.

The sequencer has three states:
- `SEQ_IDLE` moves to `SEQ_LAUNCH` when software writes 1 to the start bit.
- `SEQ_LAUNCH` always moves to `SEQ_WAIT` after one cycle. During that cycle it drives the core start pulse.
- `SEQ_WAIT` returns to `SEQ_IDLE` on the core done strobe.
- Any warm reset or standby forces the sequencer to `SEQ_IDLE`.

Top module: `adc_ctrl_unit`

## Requirements
- R1: The register map and reset values are as follows.
  - Address 0 is the mode register; channel code in bits [3:0], bits [7:4] read 0.
  - Address 1 is control; start/busy in bit 7, other bits read 0.
  - Address 2 is the result high byte.
  - Address 3 is the result low byte.
  - Address 4 is interrupt control; enable in bit 0, request flag in bit 1, other bits read 0.
  - After power-on reset, addresses 0, 1 and 4 read 0 and `irq_o` is 0.
- R2: Writing a value with bit 7 set to address 1 while idle starts a conversion. Bit 7 reads 1 from the next cycle until the conversion ends.
- R3: The start bit returns to 0 exactly CONV_CYCLES+1 clock edges after the write edge. The result registers load on that same edge.
- R4: For a RES_W=10 result `r`, the high byte is `r[9:2]` and the low byte is `{r[1:0], 6'b0}`.
- R5: Channel codes CH_BASE (4) through CH_BASE+NUM_CH-1 select input `code-4`, so code 0101 selects input 1. Every other code still runs a full conversion and gives a result of 0.
- R6: The request flag becomes 1 on the clock edge after the edge on which the start bit falls at the end of a conversion.
- R7: The request flag is sticky. Writing 0 to bit 1 of address 4 clears it, and writing 1 there leaves it unchanged.
- R8: `irq_o` is 1 exactly when both the request flag and the enable bit are 1.
- R9: A write to address 1 during a conversion is ignored, whatever its value. The start bit stays 1 and the end edge does not move.
- R10: With `lp_mode` 2'b10 or 2'b11 (standby or module standby), the mode register and the start bit are reset and a running conversion is dropped without setting the flag. The result registers and the interrupt control register keep their values.
- R11: With `lp_mode` 2'b01 (sleep), conversions run with the same timing and results as in active mode (2'b00).
- R12: A `warm_rst` pulse clears the mode, control and interrupt control registers and keeps both result registers.
- R13: The result registers change only on a conversion end edge. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| warm_rst | input | 1 | Synchronous warm reset; keeps result registers |
| lp_mode | input | 2 | Power state: 00 active, 01 sleep, 10 standby, 11 module standby |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ain_flat | input | NUM_CH*RES_W | Digitised value of each analog input, input k at bits [k*RES_W +: RES_W] |
| irq_o | output | 1 | Conversion-end interrupt request |

## Verification
The checker watches a set of properties on every cycle:
- the core start is a single-cycle pulse;
- no start reaches a core that is already converting;
- a done strobe always clears the busy bit;
- a completion fall of the busy bit always raises the flag;
- the interrupt is never asserted without an enable;
- standby clears the channel and busy state;
- the result bytes hold between done strobes.

Several behaviours can only be shown by the bench scenarios:
- the exact end latency, measured against the write edge;
- the arithmetic split of each result across the two bytes, swept over all sixteen channel codes and two input patterns;
- the ignored restart and ignored writes;
- the retention of results across a standby or warm reset, observed through later reads.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_t;

    localparam logic [2:0] ADDR_MODE = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;
    localparam logic [2:0] ADDR_RHI  = 3'd2;
    localparam logic [2:0] ADDR_RLO  = 3'd3;
    localparam logic [2:0] ADDR_IRQ  = 3'd4;

    localparam int GO_BIT   = 7;
    localparam int IEN_BIT  = 0;
    localparam int FLAG_BIT = 1;
    localparam int SEL_W    = 4;
    localparam int CH_BASE  = 4;

endpackage

// File: rtl/adc_core_model.sv
module adc_core_model
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int RES_W       = 10,
    parameter int CONV_CYCLES = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      abort,
    input  logic                      start,
    input  logic [SEL_W-1:0]          chan_sel,
    input  logic [NUM_CH*RES_W-1:0]   ain_flat,
    output logic                      done,
    output logic                      busy,
    output logic [RES_W-1:0]          result
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [RES_W-1:0] ain_arr [NUM_CH];
    logic [RES_W-1:0] sample;
    logic [RES_W-1:0] held_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
        assign ain_arr[k] = ain_flat[k*RES_W +: RES_W];
    end

    always_comb begin
        sample = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (chan_sel == SEL_W'(CH_BASE + k)) begin
                sample = ain_arr[k];
            end
        end
    end

    assign done   = busy_q && (cnt_q == LAST);
    assign busy   = busy_q;
    assign result = held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            held_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            held_q <= sample;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic go_wr_one,
    input  logic core_done,
    output logic seq_idle,
    output logic core_start,
    output logic conv_done
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (clear) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (go_wr_one) state_d = SEQ_LAUNCH;
            SEQ_LAUNCH: state_d = SEQ_WAIT;
            SEQ_WAIT:   if (core_done) state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        seq_idle   = 1'b0;
        core_start = 1'b0;
        conv_done  = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   seq_idle   = 1'b1;
            SEQ_LAUNCH: core_start = 1'b1;
            SEQ_WAIT:   conv_done  = core_done;
            default:    seq_idle   = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             ctl_clear,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             seq_idle,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             go_wr_one,
    output logic [SEL_W-1:0] chan_sel,
    output logic             go,
    output logic             irq_flag,
    output logic             irq_en,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo,
    output logic [7:0]       rdata,
    output logic             irq
);
    localparam int LO_BITS = RES_W - 8;

    logic [SEL_W-1:0] chan_q;
    logic             go_q;
    logic             go_d_q;
    logic             ien_q;
    logic             flag_q;
    logic [7:0]       hi_q;
    logic [7:0]       lo_q;
    logic             fall_seen;
    logic             unused_wbits;

    assign go_wr_one    = wr_en && (addr == ADDR_CTRL) && wdata[GO_BIT];
    assign fall_seen    = go_d_q && !go_q;
    assign unused_wbits = ^wdata[6:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            go_q   <= 1'b0;
            go_d_q <= 1'b0;
        end else if (ctl_clear) begin
            chan_q <= '0;
            go_q   <= 1'b0;
            go_d_q <= 1'b0;
        end else begin
            go_d_q <= go_q;
            if (wr_en && (addr == ADDR_MODE)) begin
                chan_q <= wdata[SEL_W-1:0];
            end
            if (conv_done) begin
                go_q <= 1'b0;
            end else if (go_wr_one && seq_idle) begin
                go_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (warm_rst) begin
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && (addr == ADDR_IRQ)) begin
                ien_q <= wdata[IEN_BIT];
                if (!wdata[FLAG_BIT]) begin
                    flag_q <= 1'b0;
                end
            end
            if (fall_seen) begin
                flag_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (conv_done && !ctl_clear) begin
            hi_q <= conv_result[RES_W-1 -: 8];
            lo_q <= 8'(conv_result[LO_BITS-1:0]) << (8 - LO_BITS);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_MODE: rdata[SEL_W-1:0] = chan_q;
            ADDR_CTRL: rdata[GO_BIT]    = go_q;
            ADDR_RHI:  rdata            = hi_q;
            ADDR_RLO:  rdata            = lo_q;
            ADDR_IRQ:  begin
                rdata[IEN_BIT]  = ien_q;
                rdata[FLAG_BIT] = flag_q;
            end
            default:   rdata = '0;
        endcase
    end

    assign chan_sel = chan_q;
    assign go       = go_q;
    assign irq_flag = flag_q;
    assign irq_en   = ien_q;
    assign res_hi   = hi_q;
    assign res_lo   = lo_q;
    assign irq      = flag_q & ien_q;

endmodule

// File: rtl/adc_ctrl_unit.sv
module adc_ctrl_unit
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int RES_W       = 10,
    parameter int CONV_CYCLES = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    warm_rst,
    input  logic [1:0]              lp_mode,
    input  logic                    bus_wr,
    input  logic [2:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_CH*RES_W-1:0] ain_flat,
    output logic                    irq_o
);
    logic             standby;
    logic             ctl_clear;
    logic             go_wr_one;
    logic             seq_idle;
    logic             core_start;
    logic             core_done;
    logic             core_busy;
    logic             conv_done;
    logic [RES_W-1:0] core_result;
    logic [SEL_W-1:0] chan_sel;
    logic             go;
    logic             irq_flag;
    logic             irq_en;
    logic [7:0]       res_hi;
    logic [7:0]       res_lo;
    logic             unused_sleep;

    assign standby      = lp_mode[1];
    assign ctl_clear    = standby | warm_rst;
    assign unused_sleep = lp_mode[0];

    adc_ctrl_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (ctl_clear),
        .go_wr_one  (go_wr_one),
        .core_done  (core_done),
        .seq_idle   (seq_idle),
        .core_start (core_start),
        .conv_done  (conv_done)
    );

    adc_core_model #(
        .NUM_CH      (NUM_CH),
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (ctl_clear),
        .start    (core_start),
        .chan_sel (chan_sel),
        .ain_flat (ain_flat),
        .done     (core_done),
        .busy     (core_busy),
        .result   (core_result)
    );

    adc_ctrl_regs #(
        .RES_W (RES_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .warm_rst    (warm_rst),
        .ctl_clear   (ctl_clear),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .seq_idle    (seq_idle),
        .conv_done   (conv_done),
        .conv_result (core_result),
        .go_wr_one   (go_wr_one),
        .chan_sel    (chan_sel),
        .go          (go),
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .res_hi      (res_hi),
        .res_lo      (res_lo),
        .rdata       (bus_rdata),
        .irq         (irq_o)
    );

endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       warm_rst,
    input logic [1:0] lp_mode,
    input logic       core_start,
    input logic       core_done,
    input logic       core_busy,
    input logic       go,
    input logic       irq_flag,
    input logic       irq_en,
    input logic       irq_o,
    input logic [3:0] chan_sel,
    input logic [7:0] res_hi,
    input logic [7:0] res_lo
);
    // R2: the core is kicked with a one-cycle pulse
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R9: no new start reaches a converting core
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> !core_start);

    // R3: a done strobe ends the busy state on the next edge
    assert_done_clears_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !warm_rst && !lp_mode[1]) |=> !go);

    // R6: a completion fall of the busy bit raises the flag
    assert_fall_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go) && !$past(lp_mode[1]) && !$past(warm_rst) && !warm_rst) |=> irq_flag);

    // R8: the interrupt needs both enable and flag
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && irq_flag));

    // R10: standby clears channel and busy state
    assert_standby_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode[1] |=> (!go && chan_sel == 4'd0));

    // R13: result bytes only move after a done strobe
    assert_results_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(core_done) |-> ($stable(res_hi) && $stable(res_lo)));

endmodule

bind adc_ctrl_unit adc_ctrl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .lp_mode    (lp_mode),
    .core_start (core_start),
    .core_done  (core_done),
    .core_busy  (core_busy),
    .go         (go),
    .irq_flag   (irq_flag),
    .irq_en     (irq_en),
    .irq_o      (irq_o),
    .chan_sel   (chan_sel),
    .res_hi     (res_hi),
    .res_lo     (res_lo)
);

// File: tb/sim_adc_ctrl_unit.sv
module sim_adc_ctrl_unit;
    localparam int NUM_CH = 8;
    localparam int RES_W  = 10;
    localparam int CONV   = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    warm_rst = 1'b0;
    logic [1:0]              lp_mode = 2'b00;
    logic                    bus_wr = 1'b0;
    logic [2:0]              bus_addr = 3'd0;
    logic [7:0]              bus_wdata = 8'd0;
    logic [7:0]              bus_rdata;
    logic [NUM_CH*RES_W-1:0] ain_flat = '0;
    logic                    irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_ctrl_unit #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .lp_mode(lp_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ain_flat(ain_flat), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [RES_W-1:0] exp_res(input int code);
        if (code >= 4 && code < 4 + NUM_CH) return ain_flat[(code-4)*RES_W +: RES_W];
        return '0;
    endfunction

    task automatic set_inputs(input int pat);
        for (int k = 0; k < NUM_CH; k++) begin
            ain_flat[k*RES_W +: RES_W] = RES_W'(k*97 + pat*331 + 13);
        end
    endtask

    // issues the start write, returns edges until busy clears
    task automatic start_wait(output int lat);
        logic [7:0] v;
        int c0;
        wr(3'd1, 8'h80);
        c0 = cyc;
        rd(3'd1, v);
        chk("R2 busy after start", int'(v), 8'h80);
        lat = -1;
        for (int i = 0; i < 100; i++) begin
            rd(3'd1, v);
            if (!v[7]) begin
                lat = cyc - c0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic chk_result(input string req, input int code);
        logic [7:0] v;
        logic [RES_W-1:0] r;
        r = exp_res(code);
        rd(3'd2, v);
        chk({req, " R4 R5 high byte"}, int'(v), int'(r[9:2]));
        rd(3'd3, v);
        chk({req, " R4 R5 low byte"}, int'(v), int'({r[1:0], 6'b0}));
    endtask

    initial begin
        logic [7:0] v, h0, l0, h1, l1;
        int lat, c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v); chk("R1 mode reset", int'(v), 0);
        rd(3'd1, v); chk("R1 ctrl reset", int'(v), 0);
        rd(3'd4, v); chk("R1 irq reg reset", int'(v), 0);
        chk("R1 irq_o reset", int'(irq_o), 0);

        // sweep of all channel codes over two input patterns
        for (int pat = 0; pat < 2; pat++) begin
            set_inputs(pat);
            for (int code = 0; code < 16; code++) begin
                logic en;
                en = code[0] ^ pat[0];
                wr(3'd0, 8'(code));
                rd(3'd0, v); chk("R1 mode readback", int'(v), code);
                wr(3'd4, {7'd0, en});
                start_wait(lat);
                chk("R3 end latency", lat, CONV + 1);
                chk_result("R3 sweep", code);
                rd(3'd4, v); chk("R6 flag not yet set", int'(v[1]), 0);
                @(negedge clk);
                rd(3'd4, v); chk("R6 flag set", int'(v), int'({6'd0, 1'b1, en}));
                chk("R8 irq with flag", int'(irq_o), int'(en));
                wr(3'd4, {6'd0, 1'b1, en});
                rd(3'd4, v); chk("R7 write 1 keeps flag", int'(v), int'({6'd0, 1'b1, en}));
                wr(3'd4, {7'd0, en});
                rd(3'd4, v); chk("R7 write 0 clears flag", int'(v), int'({7'd0, en}));
                chk("R8 irq low without flag", int'(irq_o), 0);
            end
        end

        // R9 restart and zero writes during a conversion are ignored
        rd(3'd2, h0); rd(3'd3, l0);
        wr(3'd0, 8'd5);
        wr(3'd1, 8'h80);
        c0 = cyc;
        repeat (2) @(negedge clk);
        wr(3'd1, 8'h80);
        wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R9 still busy after writes", int'(v), 8'h80);
        rd(3'd2, v); chk("R13 high held mid-conversion", int'(v), int'(h0));
        rd(3'd3, v); chk("R13 low held mid-conversion", int'(v), int'(l0));
        for (int i = 0; i < 100; i++) begin
            rd(3'd1, v);
            if (!v[7]) break;
            @(negedge clk);
        end
        chk("R9 end edge unchanged", cyc - c0, CONV + 1);
        chk_result("R9", 5);
        @(negedge clk);
        wr(3'd4, 8'h00);

        // R13 writes to result addresses ignored
        rd(3'd2, h0); rd(3'd3, l0);
        wr(3'd2, ~h0);
        wr(3'd3, ~l0);
        rd(3'd2, v); chk("R13 high write ignored", int'(v), int'(h0));
        rd(3'd3, v); chk("R13 low write ignored", int'(v), int'(l0));

        // R11 sleep mode
        lp_mode = 2'b01;
        wr(3'd0, 8'd6);
        start_wait(lat);
        chk("R11 latency in sleep", lat, CONV + 1);
        chk_result("R11", 6);
        @(negedge clk);
        rd(3'd4, v); chk("R11 flag in sleep", int'(v[1]), 1);
        lp_mode = 2'b00;
        wr(3'd4, 8'h00);

        // R10 standby and module standby drop the conversion
        for (int m = 2; m < 4; m++) begin
            rd(3'd2, h0); rd(3'd3, l0);
            wr(3'd4, 8'h01);
            wr(3'd0, 8'd9);
            wr(3'd1, 8'h80);
            repeat (3) @(negedge clk);
            lp_mode = 2'(m);
            @(negedge clk);
            lp_mode = 2'b00;
            rd(3'd0, v); chk("R10 mode cleared", int'(v), 0);
            rd(3'd1, v); chk("R10 busy cleared", int'(v), 0);
            rd(3'd4, v); chk("R10 enable held, no flag", int'(v), 1);
            repeat (30) @(negedge clk);
            rd(3'd4, v); chk("R10 no late flag", int'(v), 1);
            chk("R10 no irq", int'(irq_o), 0);
            rd(3'd2, v); chk("R10 high held", int'(v), int'(h0));
            rd(3'd3, v); chk("R10 low held", int'(v), int'(l0));
        end

        // R12 warm reset
        set_inputs(3);
        wr(3'd0, 8'd7);
        wr(3'd4, 8'h01);
        start_wait(lat);
        @(negedge clk);
        rd(3'd4, v); chk("R12 flag before warm reset", int'(v), 3);
        rd(3'd2, h1); rd(3'd3, l1);
        chk_result("R12", 7);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        rd(3'd0, v); chk("R12 mode cleared", int'(v), 0);
        rd(3'd4, v); chk("R12 irq reg cleared", int'(v), 0);
        chk("R12 irq low", int'(irq_o), 0);
        rd(3'd2, v); chk("R12 high held", int'(v), int'(h1));
        rd(3'd3, v); chk("R12 low held", int'(v), int'(l1));

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule